// File: doc/BRIEF.md
# Low-Side Switch Channel Diagnostic Controller

This block is the per-channel diagnostic and protection logic of a low-side power switch. It takes the channel's enable and command inputs and a set of raw fault flags from the analog comparators. It produces the gate enable for the power stage and one status bit for the host. When nothing is wrong, the status bit mirrors the commanded on/off state. It is inverted while a fault is being reported.

Each raw fault flag is first synchronised. It is then debounced against a slow timebase tick (nominally 250 kHz, one system-clock pulse per period). Fast faults need a short qualification window and slow faults need a long one. A qualified fault starts an error hold timer, so every reported fault stays visible on the status bit for a minimum time. Protective faults also set a fail latch that keeps the gate off. The latch is released only when the command has stayed off for longer than a channel-specific time. Shorter off periods count as ordinary PWM and leave the latch set. A lost timebase clock forces the error indication at once and switches the stage off.

Top module: `chan_diag`

## Requirements
- R1: After reset, with enable and command low, gateEn and status are both 0.
- R2: With no fault present and the fail latch clear, status and gateEn both equal en AND inCmd.
- R3: Fast faults are faultRaw bit 0 (short circuit) and bit 1 (overtemperature), which count only while on, and bit 2 (open load while on). Each is reported only after it has been present for SHORT_TICKS tick pulses in a row. A shorter pulse has no effect on status or gateEn.
- R4: Slow faults are reported only after LONG_TICKS consecutive tick pulses. They are bit 3 (open load while off, counted only while off), bit 4 (power-ground loss), bit 5 (signal-ground loss) and bit 6 (supply loss). Bits 4 to 6 count in both states.
- R5: Once a fault is reported, status stays inverted until HOLD_TICKS tick pulses after the fault disappears.
- R6: A reported short circuit, overtemperature or power-ground loss while on sets the fail latch. The latch forces gateEn to 0 and holds status at 0 while the command stays on.
- R7: The fail latch clears only after en AND inCmd has been low for LOW_TICKS tick pulses. A low period of LOW_TICKS-1 pulses leaves it set.
- R8: Open load (either state), signal-ground loss, supply loss, and power-ground loss while off are reported on status but never set the fail latch.
- R9: Two clock cycles after clkLossRaw rises, gateEn is 0 and status shows the inverted state. If the channel is on at that time, the fail latch is also set.
- R10: A fault bit that is qualified for the other state (bit 3 while on; bits 0 to 2 while off) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase pulse, nominally 250 kHz |
| en | input | 1 | Channel enable |
| inCmd | input | 1 | Channel on/off command |
| faultRaw | input | 7 | Raw asynchronous fault flags, bit order as in R3/R4 |
| clkLossRaw | input | 1 | Raw asynchronous timebase-loss flag |
| gateEn | output | 1 | Power stage gate enable |
| status | output | 1 | Diagnostic status bit |

## Verification
The embedded properties check several rules on every cycle:
- Each filter output only rises on a tick while its fault is active.
- The fail latch only falls after a completed low window, and it always blocks the gate.
- The hold timer cannot expire while a load is pending.
- A synchronised clock loss always drops the gate and inverts status.
- A fault that does not latch never sets the latch.

The exact window lengths are shown only by the bench scenarios, which sweep every fault in every state it applies to. These cover the one-tick-short filter and hold boundaries, and the one-tick-short low window that must keep the latch set.

// File: rtl/chan_diag_pkg.sv
package chan_diag_pkg;
  localparam int NFLT = 7;
  // bit order: 0 short, 1 overtemp, 2 open on, 3 open off, 4 pgnd, 5 sgnd, 6 supply
  localparam logic [NFLT-1:0] LONG_MASK  = 7'b1111000;
  localparam logic [NFLT-1:0] LATCH_MASK = 7'b0010011;
  localparam logic [NFLT-1:0] ON_ONLY    = 7'b0000111;
  localparam logic [NFLT-1:0] OFF_ONLY   = 7'b0001000;

  typedef struct packed {
    logic onState;
    logic holdLoad;
  } dp_strobe_t;
endpackage

// File: rtl/diag_sync.sv
module diag_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/diag_filter.sv
module diag_filter #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic active,
  output logic filtOut
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)                               cnt <= '0;
    else if (!active)                        cnt <= '0;
    else if (tick && cnt != W'(LIMIT))       cnt <= cnt + 1'b1;
  end

  assign filtOut = (cnt == W'(LIMIT));

  // R3 / R4: a qualified fault appears only on a tick while the fault is active
  a_r3_filter_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(filtOut) |-> ($past(tick) && $past(active)));
endmodule

// File: rtl/diag_datapath.sv
module diag_datapath
  import chan_diag_pkg::*;
#(
  parameter int SHORT_TICKS = 2,
  parameter int LONG_TICKS  = 8,
  parameter int HOLD_TICKS  = 240,
  parameter int LOW_TICKS   = 240,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic [NFLT-1:0] faultRaw,
  input  logic            clkLossRaw,
  input  dp_strobe_t      strobe,
  output logic [NFLT-1:0] filtVec,
  output logic            holdBusy,
  output logic            lowDone,
  output logic            clkLossSync
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int LW = $clog2(LOW_TICKS + 1);

  logic [NFLT:0]   syncOut;
  logic [NFLT-1:0] faultSync;
  logic [NFLT-1:0] active;
  logic [HW-1:0]   holdCnt;
  logic [LW-1:0]   lowCnt;

  diag_sync #(.WIDTH(NFLT + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({clkLossRaw, faultRaw}),
    .dout(syncOut)
  );
  assign faultSync   = syncOut[NFLT-1:0];
  assign clkLossSync = syncOut[NFLT];

  for (genvar i = 0; i < NFLT; i++) begin : g_flt
    assign active[i] = faultSync[i] &
                       (ON_ONLY[i]  ? strobe.onState  :
                        OFF_ONLY[i] ? !strobe.onState : 1'b1);
    diag_filter #(.LIMIT(LONG_MASK[i] ? LONG_TICKS : SHORT_TICKS)) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (tick),
      .active (active[i]),
      .filtOut(filtVec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     holdCnt <= '0;
    else if (strobe.holdLoad)      holdCnt <= HW'(HOLD_TICKS);
    else if (tick && holdCnt != 0) holdCnt <= holdCnt - 1'b1;
  end
  assign holdBusy = (holdCnt != 0);

  always_ff @(posedge clk) begin
    if (!rstN)                                lowCnt <= '0;
    else if (strobe.onState)                  lowCnt <= '0;
    else if (tick && lowCnt != LW'(LOW_TICKS)) lowCnt <= lowCnt + 1'b1;
  end
  assign lowDone = (lowCnt == LW'(LOW_TICKS));

  // R5: the hold window cannot end while a reported fault is still loading it
  a_r5_hold_no_early_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdBusy) |-> !$past(strobe.holdLoad));

  // R7: any on command restarts the low window
  a_r7_low_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.onState |=> !lowDone);
endmodule

// File: rtl/diag_control.sv
module diag_control
  import chan_diag_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            en,
  input  logic            inCmd,
  input  logic [NFLT-1:0] filtVec,
  input  logic            holdBusy,
  input  logic            lowDone,
  input  logic            clkLossSync,
  output dp_strobe_t      strobe,
  output logic            gateEn,
  output logic            status
);
  logic onState;
  logic latchFault;
  logic setFail;
  logic failReg;
  logic errShown;

  assign onState    = en & inCmd;
  assign latchFault = |(filtVec & LATCH_MASK);
  assign setFail    = onState & (latchFault | clkLossSync);

  always_ff @(posedge clk) begin
    if (!rstN)        failReg <= 1'b0;
    else if (setFail) failReg <= 1'b1;
    else if (lowDone) failReg <= 1'b0;
  end

  assign errShown = holdBusy | (failReg & onState) | clkLossSync;
  assign gateEn   = onState & ~failReg & ~clkLossSync;
  assign status   = onState ^ errShown;

  assign strobe.onState  = onState;
  assign strobe.holdLoad = |filtVec;

  // R6: a protective fault while on latches the stage off
  a_r6_latch_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    (onState && latchFault) |=> failReg);

  // R6 / R7: the latch always blocks the gate
  a_r6_latch_blocks_gate: assert property (@(posedge clk) disable iff (!rstN)
    failReg |-> !gateEn);

  // R7: release only after a full low window
  a_r7_release_after_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(failReg) |-> $past(lowDone));

  // R8: non-protective faults never set the latch
  a_r8_soft_no_latch: assert property (@(posedge clk) disable iff (!rstN)
    (!failReg && !clkLossSync && !latchFault) |=> !failReg);

  // R9: timebase loss drops the gate and inverts status
  a_r9_clock_loss_forces: assert property (@(posedge clk) disable iff (!rstN)
    clkLossSync |-> (!gateEn && (status == !onState)));
endmodule

// File: rtl/chan_diag.sv
module chan_diag
  import chan_diag_pkg::*;
#(
  parameter int SHORT_TICKS = 2,
  parameter int LONG_TICKS  = 8,
  parameter int HOLD_TICKS  = 240,
  parameter int LOW_TICKS   = 240,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       en,
  input  logic       inCmd,
  input  logic [6:0] faultRaw,
  input  logic       clkLossRaw,
  output logic       gateEn,
  output logic       status
);
  dp_strobe_t      strobe;
  logic [NFLT-1:0] filtVec;
  logic            holdBusy;
  logic            lowDone;
  logic            clkLossSync;

  diag_datapath #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS),
    .HOLD_TICKS (HOLD_TICKS),
    .LOW_TICKS  (LOW_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .faultRaw   (faultRaw),
    .clkLossRaw (clkLossRaw),
    .strobe     (strobe),
    .filtVec    (filtVec),
    .holdBusy   (holdBusy),
    .lowDone    (lowDone),
    .clkLossSync(clkLossSync)
  );

  diag_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .en         (en),
    .inCmd      (inCmd),
    .filtVec    (filtVec),
    .holdBusy   (holdBusy),
    .lowDone    (lowDone),
    .clkLossSync(clkLossSync),
    .strobe     (strobe),
    .gateEn     (gateEn),
    .status     (status)
  );
endmodule

// File: tb/sim_chan_diag.sv
module sim_chan_diag;
  localparam int SHORT = 2;
  localparam int LONG  = 5;
  localparam int HOLD  = 12;
  localparam int LOW   = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic en = 1'b0;
  logic inCmd = 1'b0;
  logic [6:0] faultRaw = '0;
  logic clkLossRaw = 1'b0;
  logic gateEn, status;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chan_diag #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG), .HOLD_TICKS(HOLD),
              .LOW_TICKS(LOW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .en(en), .inCmd(inCmd),
    .faultRaw(faultRaw), .clkLossRaw(clkLossRaw), .gateEn(gateEn), .status(status)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int k);
    repeat (k) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  // release a latch: low for LOW ticks, then back on
  task automatic releaseLatch(input string req);
    inCmd = 1'b0;
    ticks(LOW - 1);
    inCmd = 1'b1;
    idle(1);
    chk(req, "gate after short low", gateEn, 1'b0);
    inCmd = 1'b0;
    ticks(LOW);
    inCmd = 1'b1;
    idle(1);
    chk(req, "gate after full low", gateEn, 1'b1);
    chk(req, "status after full low", status, 1'b1);
    inCmd = 1'b0;
    idle(1);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1", "gate in reset", gateEn, 1'b0);
    chk("R1", "status in reset", status, 1'b0);
    rstN = 1'b1;
    idle(2);
    chk("R1", "gate after reset", gateEn, 1'b0);
    chk("R1", "status after reset", status, 1'b0);

    // R2: all enable/command combinations
    for (int c = 0; c < 4; c++) begin
      en = c[1];
      inCmd = c[0];
      idle(1);
      chk("R2", "status follows", status, logic'(c == 3));
      chk("R2", "gate follows", gateEn, logic'(c == 3));
    end

    // sweep every fault in every state it applies to
    for (int f = 0; f < 7; f++) begin
      for (int s = 0; s < 2; s++) begin
        bit applies = (f <= 2) ? (s == 1) : (f == 3) ? (s == 0) : 1'b1;
        bit isLong  = (f >= 3);
        bit latches = (f == 0 || f == 1 || f == 4) && (s == 1);
        int lim     = isLong ? LONG : SHORT;
        string rq   = isLong ? "R4" : "R3";
        if (!applies) continue;
        en = 1'b1;
        inCmd = logic'(s);
        idle(1);
        faultRaw = '0;
        faultRaw[f] = 1'b1;
        idle(2);
        ticks(lim - 1);
        chk(rq, $sformatf("f%0d s%0d before window", f, s), status, logic'(s));
        ticks(1);
        chk(rq, $sformatf("f%0d s%0d after window", f, s), status, logic'(s == 0));
        if (latches)
          chk("R6", $sformatf("f%0d gate latched off", f), gateEn, 1'b0);
        else
          chk("R8", $sformatf("f%0d s%0d gate unchanged", f, s), gateEn, logic'(s));
        faultRaw = '0;
        idle(3);
        ticks(HOLD - 1);
        chk("R5", $sformatf("f%0d s%0d hold last tick", f, s), status, logic'(s == 0));
        ticks(1);
        chk("R5", $sformatf("f%0d s%0d hold ended", f, s), status,
            latches ? 1'b0 : logic'(s));
        chk(latches ? "R6" : "R8", $sformatf("f%0d s%0d gate after hold", f, s), gateEn,
            latches ? 1'b0 : logic'(s));
        if (latches) releaseLatch("R7");
        inCmd = 1'b0;
        idle(1);
      end
    end

    // R3: a fast fault shorter than its window is ignored
    en = 1'b1;
    inCmd = 1'b1;
    faultRaw = 7'b0000001;
    idle(2);
    ticks(SHORT - 1);
    faultRaw = '0;
    idle(4);
    ticks(2);
    chk("R3", "short pulse status", status, 1'b1);
    chk("R3", "short pulse gate", gateEn, 1'b1);

    // R10: open-load-off flag while on is ignored
    faultRaw = 7'b0001000;
    idle(2);
    ticks(LONG + 1);
    chk("R10", "off-state fault while on status", status, 1'b1);
    chk("R10", "off-state fault while on gate", gateEn, 1'b1);
    faultRaw = '0;
    idle(3);

    // R10: on-state faults while off are ignored
    inCmd = 1'b0;
    faultRaw = 7'b0000111;
    idle(2);
    ticks(SHORT + 1);
    chk("R10", "on-state faults while off", status, 1'b0);
    faultRaw = '0;
    idle(3);
    inCmd = 1'b1;
    idle(1);
    chk("R10", "no latch left behind", gateEn, 1'b1);

    // R9: clock loss while off
    inCmd = 1'b0;
    clkLossRaw = 1'b1;
    idle(2);
    chk("R9", "off clock loss status", status, 1'b1);
    chk("R9", "off clock loss gate", gateEn, 1'b0);
    clkLossRaw = 1'b0;
    idle(2);
    chk("R9", "off clock back status", status, 1'b0);

    // R9: clock loss while on latches
    inCmd = 1'b1;
    idle(1);
    clkLossRaw = 1'b1;
    idle(2);
    chk("R9", "on clock loss gate", gateEn, 1'b0);
    chk("R9", "on clock loss status", status, 1'b0);
    clkLossRaw = 1'b0;
    idle(3);
    chk("R9", "latched after clock back", gateEn, 1'b0);
    releaseLatch("R9");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule